// File: doc/BRIEF.md
# Open Page Tracker

This block remembers, for every internal bank of every memory row, whether a DRAM page is open and which page it is. A memory controller sends it one command per cycle: an access to be classified, an activate that opens a page, a precharge that closes one bank, or a precharge-all (also used for refresh) that closes everything. For each access the tracker answers one cycle later whether the bank is empty, holds the requested page (hit) or holds some other page (miss). The controller uses that answer to pick its command sequence.

Each row can be built from devices with the full bank count or with half of it. A per-row configuration bit sets which. A command that names a bank above what its row has is flagged as illegal and leaves every entry unchanged. A policy input selects between leaving pages open after an access and closing the addressed bank as part of the access. Command scheduling, timing counters and address decoding belong to the surrounding controller.

Top module: `open_page_tracker`

## Requirements
- R1: After reset every entry is empty and `resultValid` and `illegal` are low.
- R2: An activate (`cmdOp`=1) to a row/bank stores its page. A later access (`cmdOp`=0) to the same row/bank with the same page reports hit (`classCode`=2'b01).
- R3: An access to an open bank with a different page reports miss (`classCode`=2'b10). Under the keep-open policy a miss does not replace the stored page.
- R4: An access to a bank with no open page reports empty (`classCode`=2'b00).
- R5: A precharge (`cmdOp`=2) empties only the addressed row/bank. Other banks and rows keep their pages.
- R6: A precharge-all (`cmdOp`=3) empties every entry of every row. Its row and bank fields are ignored.
- R7: With `closePolicy`=1 an access is classified from the state before it, and its bank is empty afterwards. With `closePolicy`=0 an access leaves the entry unchanged.
- R8: When `rowFullBanks[row]`=0 that row has half of `MAX_BANKS` banks. A command other than precharge-all that names a bank index at or above that count raises `illegal`, changes no entry, and an access of that kind reports empty.
- R9: `resultValid`, `classCode` and `illegal` are registered. They reflect the command presented in the previous cycle, and `resultValid` is high only after an access.
- R10: Entries of different rows are independent: the same bank index in two rows can hold different pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 2 | 0 access, 1 activate, 2 precharge, 3 precharge-all |
| cmdRow | input | 3 | Memory row index |
| cmdBank | input | 2 | Internal bank index |
| cmdPage | input | 13 | Page address for access and activate |
| closePolicy | input | 1 | 1 closes the bank after each access |
| rowFullBanks | input | 8 | Per row: 1 full bank count, 0 half |
| resultValid | output | 1 | Classification valid (one cycle after an access) |
| classCode | output | 2 | 00 empty, 01 hit, 10 miss |
| illegal | output | 1 | Previous command named a bank the row lacks |

## Verification
The directed cases go after places where a plausible design goes wrong. A precharge that wipes neighbouring banks would turn later hits into empties. A miss that overwrites the stored page would turn the next access to the old page from hit into miss. A close-policy access that clears the entry before classifying it would report empty instead of hit. An illegal activate that still writes would make a later access, after the row is switched to full banks, report hit instead of empty. Random traffic over a small set of pages, with the policy and per-row bank counts changing, is checked against a bench model of every entry. This catches row/bank index aliasing and precharge-all that misses some entries.

// File: rtl/opt_pkg.sv
package opt_pkg;
  typedef enum logic [1:0] {
    OP_ACCESS   = 2'd0,
    OP_ACTIVATE = 2'd1,
    OP_PRE      = 2'd2,
    OP_PRE_ALL  = 2'd3
  } opCode_t;

  typedef enum logic [1:0] {
    CLS_EMPTY = 2'd0,
    CLS_HIT   = 2'd1,
    CLS_MISS  = 2'd2
  } class_t;

  typedef struct packed {
    logic lookup;
    logic setEntry;
    logic clearEntry;
    logic clearAll;
    logic illegal;
  } strobe_t;
endpackage

// File: rtl/opt_ctrl.sv
module opt_ctrl
  import opt_pkg::*;
#(
  parameter int NUM_ROWS  = 8,
  parameter int MAX_BANKS = 4,
  localparam int ROW_W  = $clog2(NUM_ROWS),
  localparam int BANK_W = $clog2(MAX_BANKS)
) (
  input  logic                cmdValid,
  input  logic [1:0]          cmdOp,
  input  logic [ROW_W-1:0]    cmdRow,
  input  logic [BANK_W-1:0]   cmdBank,
  input  logic                closePolicy,
  input  logic [NUM_ROWS-1:0] rowFullBanks,
  output strobe_t             strobes
);
  localparam int HALF_BANKS = MAX_BANKS / 2;

  opCode_t op;
  logic    bankOk;

  always_comb begin
    op     = opCode_t'(cmdOp);
    bankOk = rowFullBanks[cmdRow] || (int'(cmdBank) < HALF_BANKS);

    strobes.lookup     = cmdValid && (op == OP_ACCESS);
    strobes.setEntry   = cmdValid && bankOk && (op == OP_ACTIVATE);
    strobes.clearEntry = cmdValid && bankOk &&
                         ((op == OP_PRE) || ((op == OP_ACCESS) && closePolicy));
    strobes.clearAll   = cmdValid && (op == OP_PRE_ALL);
    strobes.illegal    = cmdValid && (op != OP_PRE_ALL) && !bankOk;
  end
endmodule

// File: rtl/opt_datapath.sv
module opt_datapath
  import opt_pkg::*;
#(
  parameter int NUM_ROWS  = 8,
  parameter int MAX_BANKS = 4,
  parameter int PAGE_W    = 13,
  localparam int ROW_W     = $clog2(NUM_ROWS),
  localparam int BANK_W    = $clog2(MAX_BANKS),
  localparam int ENTRIES   = NUM_ROWS * MAX_BANKS,
  localparam int IDX_W     = ROW_W + BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ROW_W-1:0]  cmdRow,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [PAGE_W-1:0] cmdPage,
  output logic              resultValid,
  output logic [1:0]        classCode,
  output logic              illegal
);
  logic [ENTRIES-1:0] entryValid;
  logic [PAGE_W-1:0]  entryPage [ENTRIES];
  logic [IDX_W-1:0]   selIdx;
  class_t             lookupClass;

  assign selIdx = {cmdRow, cmdBank};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic selHere;
    assign selHere = (selIdx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN || strobes.clearAll) begin
        entryValid[e] <= 1'b0;
      end else if (selHere && strobes.setEntry) begin
        entryValid[e] <= 1'b1;
      end else if (selHere && strobes.clearEntry) begin
        entryValid[e] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryPage[e] <= '0;
      end else if (selHere && strobes.setEntry) begin
        entryPage[e] <= cmdPage;
      end
    end
  end

  always_comb begin
    if (strobes.illegal || !entryValid[selIdx]) begin
      lookupClass = CLS_EMPTY;
    end else if (entryPage[selIdx] == cmdPage) begin
      lookupClass = CLS_HIT;
    end else begin
      lookupClass = CLS_MISS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      classCode   <= CLS_EMPTY;
      illegal     <= 1'b0;
    end else begin
      resultValid <= strobes.lookup;
      classCode   <= strobes.lookup ? lookupClass : CLS_EMPTY;
      illegal     <= strobes.illegal;
    end
  end
endmodule

// File: rtl/open_page_tracker.sv
module open_page_tracker
  import opt_pkg::*;
#(
  parameter int NUM_ROWS  = 8,
  parameter int MAX_BANKS = 4,
  parameter int PAGE_W    = 13,
  localparam int ROW_W  = $clog2(NUM_ROWS),
  localparam int BANK_W = $clog2(MAX_BANKS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [1:0]          cmdOp,
  input  logic [ROW_W-1:0]    cmdRow,
  input  logic [BANK_W-1:0]   cmdBank,
  input  logic [PAGE_W-1:0]   cmdPage,
  input  logic                closePolicy,
  input  logic [NUM_ROWS-1:0] rowFullBanks,
  output logic                resultValid,
  output logic [1:0]          classCode,
  output logic                illegal
);
  strobe_t strobes;

  opt_ctrl #(.NUM_ROWS(NUM_ROWS), .MAX_BANKS(MAX_BANKS)) u_ctrl (
    .cmdValid    (cmdValid),
    .cmdOp       (cmdOp),
    .cmdRow      (cmdRow),
    .cmdBank     (cmdBank),
    .closePolicy (closePolicy),
    .rowFullBanks(rowFullBanks),
    .strobes     (strobes)
  );

  opt_datapath #(.NUM_ROWS(NUM_ROWS), .MAX_BANKS(MAX_BANKS), .PAGE_W(PAGE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cmdRow     (cmdRow),
    .cmdBank    (cmdBank),
    .cmdPage    (cmdPage),
    .resultValid(resultValid),
    .classCode  (classCode),
    .illegal    (illegal)
  );
endmodule

// File: rtl/opt_checker.sv
module opt_checker #(
  parameter int NUM_ROWS  = 8,
  parameter int MAX_BANKS = 4,
  localparam int ROW_W  = $clog2(NUM_ROWS),
  localparam int BANK_W = $clog2(MAX_BANKS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic [1:0]          cmdOp,
  input logic [ROW_W-1:0]    cmdRow,
  input logic [BANK_W-1:0]   cmdBank,
  input logic [NUM_ROWS-1:0] rowFullBanks,
  input logic                resultValid,
  input logic [1:0]          classCode,
  input logic                illegal
);
  // R9
  result_after_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(cmdValid && (cmdOp == 2'd0)));

  // R9
  access_gives_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == 2'd0)) |=> resultValid);

  // R4
  code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    classCode != 2'b11);

  // R8
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp != 2'd3) && !rowFullBanks[cmdRow] &&
     (int'(cmdBank) >= MAX_BANKS / 2)) |=> illegal);

  // R8
  illegal_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && illegal) |-> (classCode == 2'b00));

  // R6
  prall_not_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == 2'd3)) |=> !illegal);

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk)
    !rstN |=> (!resultValid && !illegal));
endmodule

bind open_page_tracker opt_checker #(.NUM_ROWS(NUM_ROWS), .MAX_BANKS(MAX_BANKS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdOp       (cmdOp),
  .cmdRow      (cmdRow),
  .cmdBank     (cmdBank),
  .rowFullBanks(rowFullBanks),
  .resultValid (resultValid),
  .classCode   (classCode),
  .illegal     (illegal)
);

// File: tb/sim_open_page_tracker.sv
module sim_open_page_tracker;
  localparam int ROWS = 8;
  localparam int BANKS = 4;
  localparam int PW = 13;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [1:0]  cmdOp;
  logic [2:0]  cmdRow;
  logic [1:0]  cmdBank;
  logic [12:0] cmdPage;
  logic        closePolicy;
  logic [7:0]  rowFullBanks;
  logic        resultValid;
  logic [1:0]  classCode;
  logic        illegal;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  bit        mValid [ROWS][BANKS];
  bit [12:0] mPage  [ROWS][BANKS];

  always #2 clk = ~clk;

  open_page_tracker u0 (.*);

  function automatic bit bankLegal(input logic [2:0] r, input logic [1:0] b);
    return rowFullBanks[r] || (int'(b) < BANKS / 2);
  endfunction

  function automatic logic [1:0] expClass(input logic [2:0] r, input logic [1:0] b,
                                          input logic [12:0] p);
    if (!bankLegal(r, b) || !mValid[r][b]) return 2'b00;
    return (mPage[r][b] == p) ? 2'b01 : 2'b10;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int r = 0; r < ROWS; r++)
      for (int b = 0; b < BANKS; b++) mValid[r][b] = 1'b0;
  endtask

  // Drive at negedge, check just after the next posedge, then update model.
  task automatic doCmd(input logic [1:0] op, input logic [2:0] r, input logic [1:0] b,
                       input logic [12:0] p, input string req);
    logic [1:0] eCls;
    bit eIll;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdRow = r; cmdBank = b; cmdPage = p;
    eCls = expClass(r, b, p);
    eIll = (op != 2'd3) && !bankLegal(r, b);
    @(posedge clk);
    #1;
    check({req, " valid"}, {31'd0, resultValid}, {31'd0, op == 2'd0});
    check({req, " illegal"}, {31'd0, illegal}, {31'd0, eIll});
    if (op == 2'd0) check({req, " class"}, {30'd0, classCode}, {30'd0, eCls});
    if (op == 2'd3) clearModel();
    else if (!eIll) begin
      if (op == 2'd1) begin mValid[r][b] = 1'b1; mPage[r][b] = p; end
      else if (op == 2'd2 || (op == 2'd0 && closePolicy)) mValid[r][b] = 1'b0;
    end
    cmdValid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 2'd0; cmdRow = 3'd0; cmdBank = 2'd0;
    cmdPage = 13'd0; closePolicy = 1'b0; rowFullBanks = 8'hFF;
    clearModel();
    repeat (3) @(posedge clk);
    #1;
    check("R1 resultValid", {31'd0, resultValid}, 32'd0);
    check("R1 illegal", {31'd0, illegal}, 32'd0);
    @(negedge clk); rstN = 1'b1;

    // R1 / R4: all empty after reset
    doCmd(2'd0, 3'd5, 2'd3, 13'h10, "R1 R4 empty");
    // R2 hit
    doCmd(2'd1, 3'd2, 2'd1, 13'h155, "R2 act");
    doCmd(2'd0, 3'd2, 2'd1, 13'h155, "R2 hit");
    // R3 miss, page not replaced
    doCmd(2'd0, 3'd2, 2'd1, 13'h0AA, "R3 miss");
    doCmd(2'd0, 3'd2, 2'd1, 13'h155, "R3 page kept");
    // R10 independent rows
    doCmd(2'd1, 3'd6, 2'd1, 13'h0AA, "R10 act");
    doCmd(2'd0, 3'd2, 2'd1, 13'h155, "R10 row2");
    doCmd(2'd0, 3'd6, 2'd1, 13'h0AA, "R10 row6");
    // R5 precharge only one bank
    doCmd(2'd1, 3'd2, 2'd2, 13'h077, "R5 act");
    doCmd(2'd2, 3'd2, 2'd1, 13'h0, "R5 pre");
    doCmd(2'd0, 3'd2, 2'd1, 13'h155, "R5 closed");
    doCmd(2'd0, 3'd2, 2'd2, 13'h077, "R5 neighbour");
    doCmd(2'd0, 3'd6, 2'd1, 13'h0AA, "R5 other row");
    // R7 close policy
    closePolicy = 1'b1;
    doCmd(2'd0, 3'd2, 2'd2, 13'h077, "R7 hit before close");
    doCmd(2'd0, 3'd2, 2'd2, 13'h077, "R7 empty after close");
    closePolicy = 1'b0;
    // R8 illegal bank on half row
    rowFullBanks = 8'hEF;
    doCmd(2'd1, 3'd4, 2'd3, 13'h123, "R8 illegal act");
    doCmd(2'd0, 3'd4, 2'd2, 13'h123, "R8 illegal access");
    rowFullBanks = 8'hFF;
    doCmd(2'd0, 3'd4, 2'd3, 13'h123, "R8 no write");
    // R6 precharge-all
    doCmd(2'd1, 3'd0, 2'd0, 13'h001, "R6 act");
    doCmd(2'd3, 3'd7, 2'd3, 13'h0, "R6 prall");
    doCmd(2'd0, 3'd0, 2'd0, 13'h001, "R6 empty");
    doCmd(2'd0, 3'd6, 2'd1, 13'h0AA, "R6 empty2");

    // Random traffic against the model (R2 R3 R4 R5 R6 R7 R8 R9 R10)
    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [1:0] op;
      sel = $urandom_range(0, 99);
      op = (sel < 45) ? 2'd0 : (sel < 80) ? 2'd1 : (sel < 97) ? 2'd2 : 2'd3;
      if ($urandom_range(0, 49) == 0) closePolicy = $urandom_range(0, 1);
      if ($urandom_range(0, 99) == 0) rowFullBanks = 8'($urandom);
      doCmd(op, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
            13'($urandom_range(0, 3)), "R9 random");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule